// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Up/Down Timer Counter

This block is a 16-bit timer counter that a processor with an 8-bit data bus can load and inspect. On every qualified timer tick the counter takes one of three actions: it is cleared, it steps up by one, or it steps down by one. The clear request and the direction input choose the action. A 3-bit clock-select field gates the tick input. The value zero stops the counter. Any other value lets ticks through, because division of the clock is done outside the block.

The processor sees the counter as two byte locations, chosen by a single address bit. Only the low-byte location touches the counter directly. The high-byte location is a shared 8-bit holding register. A low-byte read copies the counter's upper half into that register, so a later high-byte read returns a snapshot taken at the same instant as the low byte. A low-byte write loads the upper half from the holding register, so all sixteen bits change on one edge. Software therefore reads low then high, and writes high then low. The block reports whether the counter sits at its maximum (0xFFFF) or at zero. It also raises a single-cycle pulse when counting up wraps the value from 0xFFFF to 0x0000.

Top module: `bytectr_top`

## Requirements
- R1: After synchronous reset the counter and the holding register are 0. `at_bottom` is 1, and `at_top` and `ovf_pulse` are 0.
- R2: With `cpu_rd`=1 and `cpu_hi`=0, `cpu_rdata` shows counter bits 7:0 in that same cycle, and the clock edge copies counter bits 15:8 into the holding register. With `cpu_hi`=1, `cpu_rdata` shows the holding register.
- R3: A write with `cpu_hi`=1 loads `cpu_wdata` into the holding register only. The counter is left unchanged.
- R4: A write with `cpu_hi`=0 sets the counter to {holding register, `cpu_wdata`} on that clock edge.
- R5: A tick passed by the clock select, with `clr_req`=0, adds one to the counter when `count_down`=0 and subtracts one when `count_down`=1.
- R6: A passed tick with `clr_req`=1 sets the counter to 0, whatever the value of `count_down`.
- R7: When `clk_sel`=3'b000, ticks have no effect, but processor reads and writes still work. Every nonzero `clk_sel` value passes ticks.
- R8: A low-byte write wins over a clear or a count in the same cycle.
- R9: `at_top` is 1 exactly when the counter equals 0xFFFF, and `at_bottom` is 1 exactly when the counter equals 0.
- R10: `ovf_pulse` is 1 for exactly the one cycle after an increment moves the counter from 0xFFFF to 0x0000. It does not rise on a decrement wrap or on a write.
- R11: Decrementing from 0 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_hi | input | 1 | Byte select: 0 low byte, 1 high byte (holding register) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected byte |
| tick | input | 1 | Timer tick enable, one cycle per count |
| count_down | input | 1 | 0 counts up, 1 counts down |
| clr_req | input | 1 | Clear the counter on the next passed tick |
| clk_sel | input | 3 | Tick gate: 0 stops, nonzero passes |
| at_top | output | 1 | Counter equals 0xFFFF |
| at_bottom | output | 1 | Counter equals 0 |
| ovf_pulse | output | 1 | One-cycle pulse after an upward wrap |

## Verification
Processor access and counting can fall on the same edge. The bench provokes this in two ways. First, it asserts a low-byte write together with a tick, under both clear and count settings; the result is judged right only if the counter holds the written value exactly, with no extra step and no clear. Second, it reads the low byte of 0x12FF while an increment tick is taken. That read must return 0xFF, the following high read must return the pre-tick 0x12, and a fresh 16-bit read must then show 0x1300.

// File: rtl/bytectr_pkg.sv
package bytectr_pkg;

    localparam int CSEL_W = 3;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_LOAD  = 3'd4
    } cnt_op_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic hi;
    } cpu_req_t;

    // processor load beats every tick action; clear beats counting
    function automatic cnt_op_e pick_op(input logic load,
                                        input logic tick_ok,
                                        input logic clr,
                                        input logic down);
        cnt_op_e op;
        if (load)          op = OP_LOAD;
        else if (!tick_ok) op = OP_HOLD;
        else if (clr)      op = OP_CLEAR;
        else if (down)     op = OP_DEC;
        else               op = OP_INC;
        return op;
    endfunction

endpackage

// File: rtl/bytectr_bus.sv
module bytectr_bus
    import bytectr_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cpu_req_t         req,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] rdata,
    output logic             load_lo,
    output logic [CNT_W-1:0] load_val
);

    logic [BUS_W-1:0] hold_q;
    logic             rd_lo;
    logic             wr_hi;

    assign rd_lo    = req.rd && !req.hi;
    assign wr_hi    = req.wr &&  req.hi;
    assign load_lo  = req.wr && !req.hi;
    assign load_val = {hold_q, wdata};
    assign rdata    = req.hi ? hold_q : count[BUS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (wr_hi) hold_q <= wdata;
        else if (rd_lo) hold_q <= count[CNT_W-1:BUS_W];
    end

    // R2
    snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> hold_q == $past(count[CNT_W-1:BUS_W]));

    // R3
    hold_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> hold_q == $past(wdata));

    // R4
    load_commit_chk: assert property (@(posedge clk) disable iff (rst)
        load_lo |=> count == $past({hold_q, wdata}));

endmodule

// File: rtl/bytectr_ctrl.sv
module bytectr_ctrl
    import bytectr_pkg::*;
(
    input  logic              tick,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              clr_req,
    input  logic              count_down,
    input  logic              load_lo,
    output logic              tick_ok,
    output cnt_op_e           op
);

    assign tick_ok = tick && (|clk_sel);

    always_comb begin
        op = pick_op(load_lo, tick_ok, clr_req, count_down);
    end

endmodule

// File: rtl/bytectr_core.sv
module bytectr_core
    import bytectr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}},
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1}
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf
);

    logic [CNT_W-1:0] nxt;
    logic             wrap_up;

    always_comb begin
        case (op)
            OP_LOAD:  nxt = load_val;
            OP_CLEAR: nxt = '0;
            OP_INC:   nxt = count + ONE;
            OP_DEC:   nxt = count - ONE;
            default:  nxt = count;
        endcase
    end

    assign wrap_up   = (op == OP_INC) && (count == TOP_VAL);
    assign at_top    = (count == TOP_VAL);
    assign at_bottom = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            count <= nxt;
            ovf   <= wrap_up;
        end
    end

    // R5
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC) |=> count == $past(count) + ONE);

    // R11
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DEC && at_bottom) |=> at_top);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> at_bottom);

    // R10
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    // R10
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> at_bottom);

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(at_top && at_bottom));

endmodule

// File: rtl/bytectr_top.sv
module bytectr_top
    import bytectr_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_hi,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic [BUS_W-1:0]  cpu_rdata,
    input  logic              tick,
    input  logic              count_down,
    input  logic              clr_req,
    input  logic [CSEL_W-1:0] clk_sel,
    output logic              at_top,
    output logic              at_bottom,
    output logic              ovf_pulse
);

    cpu_req_t         req;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             load_lo;
    logic             tick_ok;
    cnt_op_e          op;

    assign req.rd = cpu_rd;
    assign req.wr = cpu_wr;
    assign req.hi = cpu_hi;

    bytectr_bus #(.BUS_W(BUS_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (cpu_wdata),
        .count    (cnt_q),
        .rdata    (cpu_rdata),
        .load_lo  (load_lo),
        .load_val (load_val)
    );

    bytectr_ctrl u_ctrl (
        .tick       (tick),
        .clk_sel    (clk_sel),
        .clr_req    (clr_req),
        .count_down (count_down),
        .load_lo    (load_lo),
        .tick_ok    (tick_ok),
        .op         (op)
    );

    bytectr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_val  (load_val),
        .count     (cnt_q),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf       (ovf_pulse)
    );

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == '0 && !(cpu_wr && !cpu_hi)) |=> $stable(cnt_q));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_hi && tick_ok) |=> cnt_q == $past(load_val));

endmodule

// File: tb/bytectr_top_tb.sv
module bytectr_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_rd, cpu_wr, cpu_hi;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic       tick, count_down, clr_req;
    logic [2:0] clk_sel;
    logic       at_top, at_bottom, ovf_pulse;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bytectr_top u_dut (
        .clk(clk), .rst(rst),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_hi(cpu_hi),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tick(tick), .count_down(count_down), .clr_req(clr_req),
        .clk_sel(clk_sel),
        .at_top(at_top), .at_bottom(at_bottom), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        cpu_rd = 1'b1; cpu_hi = 1'b0;
        #1 lo = cpu_rdata;
        step();
        cpu_hi = 1'b1;
        #1 hi = cpu_rdata;
        step();
        cpu_rd = 1'b0; cpu_hi = 1'b0;
        v = {hi, lo};
    endtask

    task automatic write16(input logic [15:0] v);
        cpu_wr = 1'b1; cpu_hi = 1'b1; cpu_wdata = v[15:8];
        step();
        cpu_hi = 1'b0; cpu_wdata = v[7:0];
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic one_tick(input logic [2:0] sel, input logic dn, input logic cl);
        clk_sel = sel; count_down = dn; clr_req = cl; tick = 1'b1;
        step();
        tick = 1'b0; clr_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, expv, base;
        rst = 1'b1; cpu_rd = 0; cpu_wr = 0; cpu_hi = 0; cpu_wdata = 0;
        tick = 0; count_down = 0; clr_req = 0; clk_sel = 3'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 bottom", at_bottom, 1);
        chk("R1 top", at_top, 0);
        chk("R1 ovf", ovf_pulse, 0);
        cpu_hi = 1'b1; #1;
        chk("R1 hold reg", cpu_rdata, 8'h00);
        cpu_hi = 1'b0;
        @(negedge clk);
        read16(v);
        chk("R1 counter", v, 16'h0000);

        // R4 R2: write/read sweep
        for (int i = 0; i < 256; i++) begin
            expv = 16'((i * 16'h0101) ^ (i * 7));
            write16(expv);
            read16(v);
            chk("R4 R2 write then read", v, expv);
        end

        // R3: high write alone leaves the counter unchanged
        write16(16'h3C5A);
        cpu_wr = 1; cpu_hi = 1; cpu_wdata = 8'hAB; step(); cpu_wr = 0;
        read16(v);
        chk("R3 high write isolated", v, 16'h3C5A);

        // R5 R6 R7: every clock select, direction and clear
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int c = 0; c < 2; c++) begin
                    base = 16'h1234 + 16'(s * 16'h0111);
                    write16(base);
                    one_tick(3'(s), 1'(d), 1'(c));
                    if (s == 0)      expv = base;
                    else if (c == 1) expv = 16'h0000;
                    else if (d == 1) expv = base - 16'd1;
                    else             expv = base + 16'd1;
                    read16(v);
                    chk(s == 0 ? "R7 stopped" : (c == 1 ? "R6 clear" : "R5 step"), v, expv);
                end
            end
        end
        clk_sel = 3'd1;

        // R9 R10: top flag, upward wrap pulse
        write16(16'hFFFF);
        #1;
        chk("R9 top at FFFF", at_top, 1);
        chk("R9 bottom at FFFF", at_bottom, 0);
        one_tick(3'd0, 1'b0, 1'b0);
        #1;
        chk("R10 no pulse when stopped", ovf_pulse, 0);
        one_tick(3'd1, 1'b0, 1'b0);
        #1;
        chk("R10 pulse after wrap", ovf_pulse, 1);
        chk("R9 bottom after wrap", at_bottom, 1);
        step(); #1;
        chk("R10 pulse one cycle", ovf_pulse, 0);

        // R11 R10: downward wrap gives FFFF and no pulse
        one_tick(3'd5, 1'b1, 1'b0);
        #1;
        chk("R11 top after down wrap", at_top, 1);
        chk("R10 no pulse on down wrap", ovf_pulse, 0);

        // R10: write of 0000 from FFFF gives no pulse
        write16(16'hFFFF);
        write16(16'h0000);
        #1;
        chk("R10 no pulse on write", ovf_pulse, 0);

        // R8: low write with tick and clear in same cycle
        cpu_wr = 1; cpu_hi = 1; cpu_wdata = 8'h55; step();
        cpu_hi = 0; cpu_wdata = 8'h66;
        clk_sel = 3'd2; tick = 1; clr_req = 1;
        step();
        cpu_wr = 0; tick = 0; clr_req = 0;
        read16(v);
        chk("R8 write over clear", v, 16'h5566);
        cpu_wr = 1; cpu_hi = 1; cpu_wdata = 8'h80; step();
        cpu_hi = 0; cpu_wdata = 8'hFF; tick = 1; count_down = 0;
        step();
        cpu_wr = 0; tick = 0;
        read16(v);
        chk("R8 write over count", v, 16'h80FF);

        // R2: low read in the same cycle as an increment
        write16(16'h12FF);
        cpu_rd = 1; cpu_hi = 0; tick = 1; count_down = 0; clk_sel = 3'd7;
        #1;
        chk("R2 low read pre-tick", cpu_rdata, 8'hFF);
        step();
        tick = 0; cpu_hi = 1; #1;
        chk("R2 snapshot high", cpu_rdata, 8'h12);
        step();
        cpu_rd = 0; cpu_hi = 0;
        read16(v);
        chk("R2 R5 value after tick", v, 16'h1300);

        // R5 R9 R10: long upward run across the wrap
        write16(16'hFF80);
        expv = 16'hFF80;
        clk_sel = 3'd3; count_down = 0;
        for (int n = 0; n < 300; n++) begin
            tick = 1;
            step();
            #1;
            chk("R10 pulse in run", ovf_pulse, (expv == 16'hFFFF) ? 1 : 0);
            expv = expv + 16'd1;
            chk("R9 bottom in run", at_bottom, (expv == 16'h0000) ? 1 : 0);
            chk("R9 top in run", at_top, (expv == 16'hFFFF) ? 1 : 0);
        end
        tick = 0;
        @(negedge clk);
        read16(v);
        chk("R5 run end value", v, expv);

        finish_run();
    end

endmodule